// File: doc/BRIEF.md
# Synthesizer Serial Latch Programming Interface

This block is the three-wire programming front end of a dual frequency synthesizer. A host drives a serial clock, a serial data line and a latch-enable strobe. The block samples all three pins into its own system clock domain. On every rising edge of the serial clock it shifts one data bit into a 22-bit word register, most significant bit first. On a rising edge of the latch-enable strobe it copies that word into one of four configuration latches: IF reference, IF divider, RF reference or RF divider. The two lowest bits of the word select the latch.

The contents of the four latches reach the synthesizer core as parallel registered fields:
- reference counter values,
- swallow and main divider counts,
- prescaler selects,
- section power-down controls,
- phase-detector polarity, charge-pump current and charge-pump three-state controls.

The serial pins are plain control pins with no handshake. The host cannot be stalled, so it must hold each level for at least `SYNC_STAGES`+1 system clocks.

Top module: `synth_prog_if`

## Requirements
- R1: After reset every latch is zero, so every output field reads zero: both sections run in normal mode with default fields.
- R2: One bit is shifted on each rising edge of `ser_clk`, most significant first, so bit 21 is the first bit received. When more than 22 bits are clocked in, only the last 22 are transferred.
- R3: Address bits [1:0] = 00 write the IF reference latch. In the reference layout, bits [15:2] are the 14-bit reference count, bit 16 is detector polarity (0 negative, 1 positive), bit 17 is pump current (0 low, 1 high) and bit 18 is pump three-state (0 normal, 1 three-state).
- R4: Address bits [1:0] = 10 write the RF reference latch, which uses the same layout as R3.
- R5: Address bits [1:0] = 01 write the IF divider latch. In the divider layout, bits [7:2] are the 6-bit swallow count and bits [18:8] are the 11-bit main count. Bit 20 is the prescaler select; on the IF side 0 means 8/9 and 1 means 16/17. Bit 21 is power-down (0 normal, 1 down).
- R6: Address bits [1:0] = 11 write the RF divider latch, which uses the same layout as R5. Its prescaler bit 20 means 32/33 when 0 and 64/65 when 1.
- R7: A latch-enable pulse changes only the addressed latch; the other three keep their contents.
- R8: A transfer happens only on a rising edge of `ser_le`. Holding it high, or toggling `ser_data` with no `ser_clk` edge, changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Latch-enable strobe, transfer on rising edge |
| if_ref_cnt | output | 14 | IF reference count |
| if_pol_pos | output | 1 | IF detector polarity, 1 positive |
| if_cp_high | output | 1 | IF pump current, 1 high |
| if_cp_tri | output | 1 | IF pump three-state |
| if_swal_cnt | output | 6 | IF swallow count |
| if_main_cnt | output | 11 | IF main count |
| if_psc_sel | output | 1 | IF prescaler select |
| if_pdown | output | 1 | IF section power-down |
| rf_ref_cnt | output | 14 | RF reference count |
| rf_pol_pos | output | 1 | RF detector polarity, 1 positive |
| rf_cp_high | output | 1 | RF pump current, 1 high |
| rf_cp_tri | output | 1 | RF pump three-state |
| rf_swal_cnt | output | 6 | RF swallow count |
| rf_main_cnt | output | 11 | RF main count |
| rf_psc_sel | output | 1 | RF prescaler select |
| rf_pdown | output | 1 | RF section power-down |

## Verification
The bench streams words longer than 22 bits. A register that keeps its oldest bits, or shifts least significant bit first, then lands the word in the wrong latch with scrambled fields. It toggles the data line with no clock edge and holds the strobe high across a whole new word. A level-sensitive transfer, or one without edge detection, would then update a latch early or write it twice. Every write is followed by a check of all four latches, so a decoder that writes more than the addressed latch, or that swaps the IF and RF addresses, shows up as a miscompare on a latch that was not addressed. Random words cover all four addresses with every field bit pattern.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int WORD_W = 22;
  localparam int NUM_LATCH = 4;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_IF_REF = 2'b00,
    SEL_IF_DIV = 2'b01,
    SEL_RF_REF = 2'b10,
    SEL_RF_DIV = 2'b11
  } latch_sel_e;

  // reference layout
  localparam int REF_CNT_LO = 2;
  localparam int REF_CNT_W = 14;
  localparam int REF_POL_BIT = 16;
  localparam int REF_CUR_BIT = 17;
  localparam int REF_TRI_BIT = 18;

  // divider layout
  localparam int SWAL_LO = 2;
  localparam int SWAL_W = 6;
  localparam int MAIN_LO = 8;
  localparam int MAIN_W = 11;
  localparam int PSC_BIT = 20;
  localparam int PDN_BIT = 21;
endpackage

// File: rtl/prog_pin_sync.sv
module prog_pin_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_sync
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= pin_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/prog_shift_reg.sv
module prog_shift_reg
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], din};
  end

  // R2: newest bit enters at the least significant end, older bits move up
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (word[0] == $past(din)) && (word[WORD_W-1:1] == $past(word[WORD_W-2:0])));
  // R8: without a serial clock edge the word is frozen
  p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(word));
endmodule

// File: rtl/prog_latch_bank.sv
module prog_latch_bank
  import synth_prog_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [WORD_W-1:0]                  word,
  output logic [NUM_LATCH-1:0][WORD_W-1:0]   lat
);
  logic [NUM_LATCH-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_LATCH; g++) begin : g_latch
      assign hit[g] = wr_en && (word[ADDR_W-1:0] == ADDR_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat[g] <= '0;
        else if (hit[g]) lat[g] <= word;
      end
      // R7: an unaddressed latch keeps its contents
      p_keep_other_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit[g] |=> $stable(lat[g]));
      // R3: the addressed latch takes the whole word
      p_take_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit[g] |=> lat[g] == $past(word));
    end
  endgenerate

  // R7: at most one latch per strobe
  p_one_target_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data,
  input  logic        ser_le,
  output logic [13:0] if_ref_cnt,
  output logic        if_pol_pos,
  output logic        if_cp_high,
  output logic        if_cp_tri,
  output logic [5:0]  if_swal_cnt,
  output logic [10:0] if_main_cnt,
  output logic        if_psc_sel,
  output logic        if_pdown,
  output logic [13:0] rf_ref_cnt,
  output logic        rf_pol_pos,
  output logic        rf_cp_high,
  output logic        rf_cp_tri,
  output logic [5:0]  rf_swal_cnt,
  output logic [10:0] rf_main_cnt,
  output logic        rf_psc_sel,
  output logic        rf_pdown
);
  logic [2:0] pins_s;
  logic       sclk_d, le_d;
  logic       sclk_rise, le_rise;
  logic [WORD_W-1:0] word;
  logic [NUM_LATCH-1:0][WORD_W-1:0] lat;

  prog_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pin_in({ser_le, ser_data, ser_clk}),
    .pin_sync(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      le_d   <= 1'b0;
    end else begin
      sclk_d <= pins_s[0];
      le_d   <= pins_s[2];
    end
  end

  assign sclk_rise = pins_s[0] & ~sclk_d;
  assign le_rise   = pins_s[2] & ~le_d;

  // R8: an edge detector fires for one cycle per edge
  p_le_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> !le_rise);
  p_sclk_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);

  prog_shift_reg u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(sclk_rise), .din(pins_s[1]),
    .word(word)
  );

  prog_latch_bank u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(le_rise), .word(word),
    .lat(lat)
  );

  assign if_ref_cnt  = lat[SEL_IF_REF][REF_CNT_LO +: REF_CNT_W];
  assign if_pol_pos  = lat[SEL_IF_REF][REF_POL_BIT];
  assign if_cp_high  = lat[SEL_IF_REF][REF_CUR_BIT];
  assign if_cp_tri   = lat[SEL_IF_REF][REF_TRI_BIT];
  assign if_swal_cnt = lat[SEL_IF_DIV][SWAL_LO +: SWAL_W];
  assign if_main_cnt = lat[SEL_IF_DIV][MAIN_LO +: MAIN_W];
  assign if_psc_sel  = lat[SEL_IF_DIV][PSC_BIT];
  assign if_pdown    = lat[SEL_IF_DIV][PDN_BIT];
  assign rf_ref_cnt  = lat[SEL_RF_REF][REF_CNT_LO +: REF_CNT_W];
  assign rf_pol_pos  = lat[SEL_RF_REF][REF_POL_BIT];
  assign rf_cp_high  = lat[SEL_RF_REF][REF_CUR_BIT];
  assign rf_cp_tri   = lat[SEL_RF_REF][REF_TRI_BIT];
  assign rf_swal_cnt = lat[SEL_RF_DIV][SWAL_LO +: SWAL_W];
  assign rf_main_cnt = lat[SEL_RF_DIV][MAIN_LO +: MAIN_W];
  assign rf_psc_sel  = lat[SEL_RF_DIV][PSC_BIT];
  assign rf_pdown    = lat[SEL_RF_DIV][PDN_BIT];

  // R8: outputs move only in the cycle after a strobe edge
  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> $stable({if_ref_cnt, if_swal_cnt, if_main_cnt, if_pdown,
                          rf_ref_cnt, rf_swal_cnt, rf_main_cnt, rf_pdown}));

  // lat bits 19 and word-wide reserved bits feed no output
  logic unused_bits;
  assign unused_bits = ^{lat[0][21:19], lat[0][1:0], lat[1][19], lat[1][1:0],
                         lat[2][21:19], lat[2][1:0], lat[3][19], lat[3][1:0]};
endmodule

// File: tb/synth_prog_if_bench.sv
module synth_prog_if_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [13:0] if_ref_cnt, rf_ref_cnt;
  logic if_pol_pos, if_cp_high, if_cp_tri, if_psc_sel, if_pdown;
  logic rf_pol_pos, rf_cp_high, rf_cp_tri, rf_psc_sel, rf_pdown;
  logic [5:0] if_swal_cnt, rf_swal_cnt;
  logic [10:0] if_main_cnt, rf_main_cnt;

  int vectors = 0;
  int errors = 0;
  logic [21:0] model [4];

  always #2.5 clk = ~clk;

  synth_prog_if u_synth_prog_if (.*);

  function automatic logic [16:0] ref_view(logic [21:0] w);
    return {w[18], w[17], w[16], w[15:2]};
  endfunction
  function automatic logic [18:0] div_view(logic [21:0] w);
    return {w[21], w[20], w[18:8], w[7:2]};
  endfunction

  task automatic chk(string req, logic [18:0] act, logic [18:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic shift_bit(logic b);
    ser_data = b; wait_clk(4);
    ser_clk = 1'b1; wait_clk(4);
    ser_clk = 1'b0; wait_clk(4);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1; wait_clk(5);
    ser_le = 1'b0; wait_clk(5);
  endtask

  task automatic check_all(string hit_req, int hit);
    @(negedge clk);
    chk(hit == 0 ? hit_req : "R7", {2'b0, if_cp_tri, if_cp_high, if_pol_pos, if_ref_cnt}, {2'b0, ref_view(model[0])});
    chk(hit == 1 ? hit_req : "R7", {if_pdown, if_psc_sel, if_main_cnt, if_swal_cnt}, div_view(model[1]));
    chk(hit == 2 ? hit_req : "R7", {2'b0, rf_cp_tri, rf_cp_high, rf_pol_pos, rf_ref_cnt}, {2'b0, ref_view(model[2])});
    chk(hit == 3 ? hit_req : "R7", {rf_pdown, rf_psc_sel, rf_main_cnt, rf_swal_cnt}, div_view(model[3]));
  endtask

  function automatic string req_of(logic [1:0] a);
    case (a)
      2'b00: return "R3";
      2'b01: return "R5";
      2'b10: return "R4";
      default: return "R6";
    endcase
  endfunction

  task automatic write_word(logic [21:0] w);
    for (int i = 21; i >= 0; i--) shift_bit(w[i]);
    pulse_le();
    model[w[1:0]] = w;
    check_all(req_of(w[1:0]), int'(w[1:0]));
  endtask

  initial begin
    for (int k = 0; k < 4; k++) model[k] = '0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    check_all("R1", -1);

    // directed: each latch all ones
    write_word(22'h3FFFFC);
    write_word(22'h3FFFFD);
    write_word(22'h3FFFFE);
    write_word(22'h3FFFFF);
    // directed: field isolation patterns
    write_word({3'b000, 1'b1, 16'hA5C3, 2'b00});
    write_word({1'b0, 1'b1, 1'b0, 11'h4D2, 6'h15, 2'b01});
    write_word({1'b1, 1'b0, 1'b0, 11'h001, 6'h3E, 2'b11});

    // R2: 30-bit stream, only last 22 bits count
    begin
      logic [21:0] w = {1'b1, 1'b1, 1'b0, 11'h2AB, 6'h07, 2'b01};
      for (int i = 0; i < 8; i++) shift_bit(1'b1);
      for (int i = 21; i >= 0; i--) shift_bit(w[i]);
      pulse_le();
      model[1] = w;
      check_all("R2", 1);
    end

    // R8: toggle data without clock edges, then re-strobe same word
    for (int i = 0; i < 6; i++) begin ser_data = ~ser_data; wait_clk(3); end
    wait_clk(6);
    check_all("R8", -1);
    pulse_le();
    check_all("R8", -1);

    // R8: strobe held high while a new word is shifted: no transfer
    begin
      logic [21:0] w = {3'b001, 1'b0, 16'h1234, 2'b10};
      ser_le = 1'b1; wait_clk(5);
      for (int i = 21; i >= 0; i--) shift_bit(w[i]);
      check_all("R8", -1);
      ser_le = 1'b0; wait_clk(5);
      check_all("R8", -1);
      pulse_le();
      model[2] = w;
      check_all("R4", 2);
    end

    // random words
    void'($urandom(32'h1F2E3D4C));
    for (int n = 0; n < 60; n++) write_word(22'($urandom()));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule